// File: doc/BRIEF.md
# Oversampling Serial Receiver with Break Detection

This block recovers asynchronous serial characters from a single receive line. The line is first brought into the clock domain through a two-stage synchronizer. It is then sampled on a 16x baud tick supplied from outside. The character format (5 to 8 data bits, optional parity of either sense) comes from plain configuration pins. The format is captured when a start bit is seen, so the pins may change while a character is arriving.

A completed character lands in a single holding register. There is no queue. The holding register is offered on a valid/ready output. `rx_valid` is the data-ready flag itself, and a transfer takes place on any clock where `rx_valid` and `rx_ready` are both high. Back-pressure has a limit: while the consumer leaves a byte unread, the receiver keeps running, and each character that completes in that time is dropped and flagged as an overrun. A line held at zero for a whole character is reported once as a break: the holding register holds zero, and the break and data-ready flags are set together.

Five status flags are presented on `line_status`. A status-read strobe clears the three error flags. A one-cycle `frame_stb` pulse marks every completed character, so a register bank can update its interrupt logic.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `rx_valid` is 0, `rx_data` is 0x00 and `line_status` is 0.
- R2: A character has a start bit and then 5 + `char_len` data bits, LSB first, with 16 ticks per bit. Each bit is sampled near its centre. Data bits above the character length read as 0 in `rx_data`.
- R3: When `par_en` is 1, a parity bit follows the data bits. `par_even` = 1 selects even parity and 0 selects odd parity. A mismatch sets the parity-error flag, `line_status` bit 2.
- R4: A zero stop bit on a character that is not a break sets the framing-error flag, `line_status` bit 3. The data is still stored.
- R5: A character whose data, parity and stop bits are all zero is a break. It stores 0x00 and sets the break flag (bit 4) together with data-ready (bit 0). It does not set the framing-error or parity-error flag.
- R6: After a zero stop bit, the receiver waits for the line to return high before it looks for a new start bit, so a long break yields exactly one character.
- R7: `rx_valid` equals the data-ready flag (bit 0). A transfer (`rx_valid` and `rx_ready` both high) clears both data-ready and break.
- R8: A character that completes while data-ready is set, with no transfer in that cycle, sets the overrun flag (bit 1). The holding register keeps its old byte.
- R9: A `status_rd` pulse clears the overrun, parity-error and framing-error flags. A flag set in the same cycle stays set.
- R10: A low level on the line that is no longer low 8 ticks after it was first seen is ignored and produces no character.
- R11: Changes to `char_len`, `par_en` or `par_even` after a start bit has been detected do not affect that character.
- R12: `frame_stb` pulses for exactly one cycle per completed character. This includes overrun and break characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_16x | input | 1 | One-cycle enable, 16 per bit time |
| rx_pin | input | 1 | Asynchronous serial receive line, idle high |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| rx_data | output | 8 | Holding register |
| rx_valid | output | 1 | Holding register contains an unread byte |
| rx_ready | input | 1 | Consumer takes the byte when high with rx_valid |
| status_rd | input | 1 | Pulse that clears the error flags |
| line_status | output | 5 | {break, framing, parity, overrun, data ready} |
| frame_stb | output | 1 | One-cycle pulse per completed character |

## Verification
Valid characters are swept over every length and every parity mode. For each combination the bench sends walking-one, all-ones and mixed patterns, which expose bit-order, length and parity-sense faults. Single faults are then injected, each alone: an inverted parity bit, a zero stop bit on nonzero data, and a line held low for many bit times. These tell apart the parity-error, framing-error and break paths. A second character sent with the first one unread checks the overrun rule. A short low glitch and a format change in the middle of a character check start validation and format capture.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W = 8;
  localparam int LS_DR  = 0;
  localparam int LS_OE  = 1;
  localparam int LS_PE  = 2;
  localparam int LS_FE  = 3;
  localparam int LS_BI  = 4;
  localparam int LS_W   = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAIT_HI
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_even;
  } frame_cfg_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
  } frame_res_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  frame_cfg_t cfg,
  output logic       done,
  output frame_res_t res
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OVERSAMPLE - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [2:0]        idx;
  logic [2:0]        last_idx;
  frame_cfg_t        cfg_q;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic              is_brk, perr_c, ferr_c;

  always_comb begin
    last_idx = 3'd4 + {1'b0, cfg_q.len};
    is_brk   = !rx && (shreg == '0) && !pbit;
    perr_c   = cfg_q.par_en && ((^shreg ^ pbit) ^ ~cfg_q.par_even) && !is_brk;
    ferr_c   = !rx && !is_brk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      cfg_q <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
      done  <= 1'b0;
      res   <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: if (!rx) begin
            state <= ST_START;
            cnt   <= '0;
            cfg_q <= cfg;
          end
          ST_START: if (cnt == MID) begin
            if (!rx) begin
              state <= ST_DATA;
              cnt   <= '0;
              idx   <= '0;
              shreg <= '0;
              pbit  <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end else cnt <= cnt + 1'b1;
          ST_DATA: if (cnt == FULL) begin
            cnt        <= '0;
            shreg[idx] <= rx;
            if (idx == last_idx) state <= cfg_q.par_en ? ST_PAR : ST_STOP;
            else                 idx   <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
          ST_PAR: if (cnt == FULL) begin
            cnt   <= '0;
            pbit  <= rx;
            state <= ST_STOP;
          end else cnt <= cnt + 1'b1;
          ST_STOP: if (cnt == FULL) begin
            cnt      <= '0;
            done     <= 1'b1;
            res.data <= shreg;
            res.perr <= perr_c;
            res.ferr <= ferr_c;
            res.brk  <= is_brk;
            state    <= rx ? ST_IDLE : ST_WAIT_HI;
          end else cnt <= cnt + 1'b1;
          ST_WAIT_HI: if (rx) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_stb_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_cfg_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(cfg_q));
endmodule

// File: rtl/srx_holding.sv
module srx_holding
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  frame_res_t        res,
  input  logic              ready,
  input  logic              status_rd,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic [LS_W-1:0]   status
);
  logic dr, oe, pe, fe, bi;
  logic pop, accept;

  assign pop    = dr && ready;
  assign accept = done && (!dr || pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      {dr, oe, pe, fe, bi} <= '0;
    end else begin
      if (pop) begin
        dr <= 1'b0;
        bi <= 1'b0;
      end
      if (status_rd) begin
        oe <= 1'b0;
        pe <= 1'b0;
        fe <= 1'b0;
      end
      if (accept) begin
        data <= res.brk ? '0 : res.data;
        dr   <= 1'b1;
        bi   <= res.brk;
        if (res.perr) pe <= 1'b1;
        if (res.ferr) fe <= 1'b1;
      end else if (done) begin
        oe <= 1'b1;
      end
    end
  end

  always_comb begin
    status        = '0;
    status[LS_DR] = dr;
    status[LS_OE] = oe;
    status[LS_PE] = pe;
    status[LS_FE] = fe;
    status[LS_BI] = bi;
  end
  assign valid = dr;

  assert_pop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !done) |=> (!dr && !bi));
  assert_break_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bi |-> (data == '0 && dr));
  assert_overrun_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dr && !ready) |=> ($stable(data) && oe));
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_16x,
  input  logic              rx_pin,
  input  logic [1:0]        char_len,
  input  logic              par_en,
  input  logic              par_even,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic              status_rd,
  output logic [LS_W-1:0]   line_status,
  output logic              frame_stb
);
  logic       rx_s;
  frame_cfg_t cfg;
  frame_res_t res;

  assign cfg = '{len: char_len, par_en: par_en, par_even: par_even};

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_pin), .dout(rx_s)
  );

  srx_framer #(.OVERSAMPLE(OVERSAMPLE)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick_16x), .rx(rx_s), .cfg(cfg),
    .done(frame_stb), .res(res)
  );

  srx_holding u_hold (
    .clk(clk), .rst_n(rst_n), .done(frame_stb), .res(res),
    .ready(rx_ready), .status_rd(status_rd),
    .data(rx_data), .valid(rx_valid), .status(line_status)
  );
endmodule

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;
  localparam int BIT_CLKS = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_16x = 1'b0;
  logic       rx_pin = 1'b1;
  logic [1:0] char_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       rx_ready = 1'b0;
  logic       status_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic [4:0] line_status;
  logic       frame_stb;

  int checks = 0;
  int fails = 0;
  int stb_cnt = 0;

  serial_rx_core uut (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .rx_pin(rx_pin),
    .char_len(char_len), .par_en(par_en), .par_even(par_even),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .status_rd(status_rd), .line_status(line_status), .frame_stb(frame_stb)
  );

  always #5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick_16x = ~tick_16x;
  end

  always @(posedge clk) if (frame_stb) stb_cnt++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx_pin = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                            input bit pev, input bit bad_par, input logic stop_v,
                            input bit swap_cfg);
    logic pb;
    pb = pev ? ^d : ~^d;
    if (bad_par) pb = ~pb;
    drive_bit(1'b0);
    if (swap_cfg) begin
      char_len = 2'd0;
      par_en   = 1'b1;
    end
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (pen) drive_bit(pb);
    drive_bit(stop_v);
    rx_pin = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
  endtask

  task automatic pop_byte;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic read_status;
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
  endtask

  task automatic set_cfg(input int nb, input bit pen, input bit pev);
    char_len = 2'(nb - 5);
    par_en   = pen;
    par_even = pev;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int s0;
    logic [7:0] d;
    logic [7:0] mask;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 valid", rx_valid, 0);
    check("R1 data", rx_data, 0);
    check("R1 status", line_status, 0);

    // R2 / R3 sweep of lengths, parity modes and patterns; R12 one strobe each
    for (int nb = 5; nb <= 8; nb++) begin
      for (int m = 0; m < 3; m++) begin
        for (int k = 0; k < 10; k++) begin
          mask = 8'((1 << nb) - 1);
          d = (k < 8) ? 8'(1 << k) : ((k == 8) ? 8'hFF : 8'h5A);
          d = d & mask;
          if (d == 8'h00) d = mask;
          set_cfg(nb, m != 0, m == 2);
          s0 = stb_cnt;
          send_frame(d, nb, m != 0, m == 2, 1'b0, 1'b1, 1'b0);
          check("R2 data", rx_data, d);
          check("R3 status clean", line_status, 5'b00001);
          check("R12 one strobe", stb_cnt - s0, 1);
          pop_byte();
          check("R7 valid cleared", rx_valid, 0);
        end
      end
    end

    // R3 parity error injection, odd and even
    for (int m = 0; m < 2; m++) begin
      set_cfg(7, 1'b1, m == 1);
      send_frame(8'h2D, 7, 1'b1, m == 1, 1'b1, 1'b1, 1'b0);
      check("R3 parity error", line_status, 5'b00101);
      check("R3 data kept", rx_data, 8'h2D);
      pop_byte();
      check("R9 pe sticky", line_status, 5'b00100);
      read_status();
      check("R9 pe cleared", line_status, 5'b00000);
    end

    // R4 framing error, R6 recovery after line returns high
    set_cfg(8, 1'b0, 1'b0);
    send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R4 framing", line_status, 5'b01001);
    check("R4 data", rx_data, 8'h3C);
    pop_byte();
    read_status();
    send_frame(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R6 next frame data", rx_data, 8'h81);
    check("R6 next frame status", line_status, 5'b00001);
    pop_byte();

    // R5 / R6 long break yields one break character
    s0 = stb_cnt;
    rx_pin = 1'b0;
    repeat (30 * BIT_CLKS) @(negedge clk);
    rx_pin = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    check("R5 break status", line_status, 5'b10001);
    check("R5 break data", rx_data, 8'h00);
    check("R6 single break", stb_cnt - s0, 1);
    pop_byte();
    check("R7 break cleared", line_status, 5'b00000);

    // R8 overrun: second byte while first unread
    s0 = stb_cnt;
    send_frame(8'hA7, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    send_frame(8'h19, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R8 old byte kept", rx_data, 8'hA7);
    check("R8 overrun set", line_status, 5'b00011);
    check("R12 overrun strobe", stb_cnt - s0, 2);
    pop_byte();
    check("R9 oe sticky", line_status, 5'b00010);
    read_status();
    check("R9 oe cleared", line_status, 5'b00000);

    // R10 short glitch ignored
    s0 = stb_cnt;
    rx_pin = 1'b0;
    repeat (6) @(negedge clk);
    rx_pin = 1'b1;
    repeat (12 * BIT_CLKS) @(negedge clk);
    check("R10 glitch no valid", rx_valid, 0);
    check("R10 glitch no strobe", stb_cnt - s0, 0);

    // R11 format change after start bit
    set_cfg(8, 1'b0, 1'b0);
    send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R11 data", rx_data, 8'hC3);
    check("R11 status", line_status, 5'b00001);
    pop_byte();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule